// File: doc/BRIEF.md
# Sensor Register SPI Master

This block lets a host read and write the 16-bit registers of an inertial sensor over SPI, one word per chip-select frame. The host offers a request (read or write, a 7-bit byte address and a data byte) while `busy` is low. The block packs it into a 16-bit command word and shifts it out MSB first. SCLK idles high. DIN changes only on SCLK falling edges and is stable at every rising edge, where the sensor samples it. DOUT is captured on the same rising edges.

The sensor returns read data one frame late: a read request's answer comes in during the next frame, whatever that frame carries. The block keeps track of the outstanding read. When that next frame ends, it pulses `rvalid` with the 16-bit word. If the host has nothing more to send while a read is outstanding, the block sends an all-zero read frame of its own to collect the answer. Between frames, chip select stays high for at least a programmed number of system clock cycles.

Writes carry one byte. An even byte address targets bits 7:0 of a register and the odd address above it targets bits 15:8, so a full word takes two write frames. `CLK_DIV` sets the length of each SCLK half period and `STALL_CYC` sets the minimum chip-select-high gap, both in system clock cycles.

Top module: `spi_reg_master`

## Requirements
- R1: While reset is held, `spi_cs_n` and `spi_sclk` are 1, and `busy` and `rvalid` are 0.
- R2: The frame word is {we, addr[6:0], data[7:0]} with we=1 for a write, and data forced to 0 for a read. It is sent MSB first. DIN changes only when CS falls or SCLK falls, so the sensor reads the word exactly on the rising edges.
- R3: A write to an even byte address replaces bits 7:0 of register addr[6:1], and one to an odd address replaces bits 15:8. The other byte of that register is left unchanged.
- R4: For every read request, `rvalid` pulses once, with `rdata` holding the register value. The pulse comes in the cycle CS rises at the end of the frame after the one that carried the request.
- R5: Back-to-back read requests need no extra frames: each read frame also collects the response to the read before it.
- R6: If a read is outstanding and no request is present in the idle cycle after the stall, the block sends a read frame of 0x0000 on its own. That frame does not create a new outstanding read.
- R7: Between two frames, CS stays high for at least `STALL_CYC` system clock cycles.
- R8: SCLK is high whenever CS is high. Each frame has exactly 16 rising SCLK edges, and each low phase lasts exactly `CLK_DIV` cycles.
- R9: A request is taken only in a cycle where `busy` is low. `busy` is high whenever CS is low, and a request raised while busy has no effect.
- R10: A write frame that follows a write or an idle bus gives no `rvalid`, and no dummy frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken while busy is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 7 | Sensor byte address |
| wdata | input | 8 | Write data byte |
| busy | output | 1 | Frame or stall in progress |
| rvalid | output | 1 | One-cycle pulse: rdata holds a read response |
| rdata | output | 16 | Read response word |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the sensor (DIN) |
| spi_miso | input | 1 | Serial data from the sensor (DOUT) |

## Verification
The hardest case to reach is a request that arrives while a frame is already under way. The bench waits until chip select is low, raises a write request for one cycle, and then reads the targeted register back through the normal read path to show it did not change. The dummy collection frame needs the host to go quiet right after a read, so the bench ends several sequences on a read and counts frames at the bench's model sensor. That model keeps its own register array. It answers each frame with the word selected by the read before it, so a misaligned response shows up in the scoreboard as wrong data.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CMD_ADDR_W = 7;
  localparam int CMD_DATA_W = 8;
  localparam int FRAME_W    = 1 + CMD_ADDR_W + CMD_DATA_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_STALL = 2'd2
  } xfer_state_t;

  // Command word: flag, byte address, byte (zeroed for reads).
  function automatic logic [FRAME_W-1:0] make_cmd(
    input logic                  wr,
    input logic [CMD_ADDR_W-1:0] a,
    input logic [CMD_DATA_W-1:0] d
  );
    logic [CMD_DATA_W-1:0] payload;
    payload = wr ? d : '0;
    return {wr, a, payload};
  endfunction

  // Odd half-phase index means SCLK goes high at its end.
  function automatic logic is_rise_step(input logic [7:0] step);
    return step[0];
  endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  assign mosi    = tx_q[W-1];
  assign rx_word = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
    end else if (shift) begin
      tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= {rx_q[W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_reg_pkg::*;
#(
  parameter int STALL_CYC = 2000,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic we,
  input  logic tick,
  output logic busy,
  output logic run,
  output logic launch,
  output logic host_go,
  output logic shift_en,
  output logic sample_en,
  output logic frame_done,
  output logic deliver,
  output logic cs_n,
  output logic sclk,
  output logic rvalid
);
  localparam int EDGES = 2 * FRAME_BITS;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int SW    = (STALL_CYC > 1) ? $clog2(STALL_CYC + 1) : 1;

  xfer_state_t   st;
  logic [EW-1:0] step;
  logic [SW-1:0] stall_cnt;
  logic          pend;
  logic          collect_q;
  logic          dummy_go;
  logic          in_xfer;
  logic          last_step;
  logic          rise_step;

  assign in_xfer    = (st == ST_XFER);
  assign run        = in_xfer;
  assign busy       = (st != ST_IDLE);
  assign host_go    = (st == ST_IDLE) && req;
  assign dummy_go   = (st == ST_IDLE) && !req && pend;
  assign launch     = host_go || dummy_go;
  assign last_step  = (step == EW'(EDGES));
  assign rise_step  = is_rise_step(8'(step));
  assign frame_done = in_xfer && tick && last_step;
  assign sample_en  = in_xfer && tick && rise_step;
  assign shift_en   = in_xfer && tick && !rise_step && !last_step && (step != '0);
  assign deliver    = frame_done && collect_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      step      <= '0;
      stall_cnt <= '0;
      pend      <= 1'b0;
      collect_q <= 1'b0;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (launch) begin
            st        <= ST_XFER;
            cs_n      <= 1'b0;
            sclk      <= 1'b1;
            step      <= '0;
            collect_q <= pend;
            pend      <= host_go && !we;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (last_step) begin
              st        <= ST_STALL;
              cs_n      <= 1'b1;
              sclk      <= 1'b1;
              rvalid    <= collect_q;
              stall_cnt <= '0;
            end else begin
              step <= step + 1'b1;
              sclk <= rise_step;
            end
          end
        end
        ST_STALL: begin
          if (stall_cnt == SW'(STALL_CYC - 1)) begin
            st <= ST_IDLE;
          end else begin
            stall_cnt <= stall_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int CLK_DIV   = 32,
  parameter int STALL_CYC = 2000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [CMD_ADDR_W-1:0] addr,
  input  logic [CMD_DATA_W-1:0] wdata,
  output logic                  busy,
  output logic                  rvalid,
  output logic [FRAME_W-1:0]    rdata,
  output logic                  spi_cs_n,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  input  logic                  spi_miso
);
  logic               tick;
  logic               run;
  logic               frame_start;
  logic               host_go;
  logic               shift_en;
  logic               sample_en;
  logic               frame_done;
  logic               deliver;
  logic [FRAME_W-1:0] cmd_word;
  logic [FRAME_W-1:0] rx_word;
  logic [FRAME_W-1:0] rdata_q;

  assign cmd_word = host_go ? make_cmd(we, addr, wdata) : '0;
  assign rdata    = rdata_q;

  spi_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  spi_frame_seq #(.STALL_CYC(STALL_CYC), .FRAME_BITS(FRAME_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .tick      (tick),
    .busy      (busy),
    .run       (run),
    .launch    (frame_start),
    .host_go   (host_go),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .frame_done(frame_done),
    .deliver   (deliver),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .rvalid    (rvalid)
  );

  spi_shift_unit #(.W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .load_word(cmd_word),
    .shift    (shift_en),
    .sample   (sample_en),
    .miso     (spi_miso),
    .mosi     (spi_mosi),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (deliver) begin
      rdata_q <= rx_word;
    end
  end
endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk #(
  parameter int CLK_DIV   = 32,
  parameter int STALL_CYC = 2000,
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic rvalid,
  input logic frame_start,
  input logic frame_done
);
  logic        cs_q;
  logic        sclk_q;
  logic [31:0] gap_cnt;
  logic [31:0] ph_cnt;
  logic [7:0]  rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      gap_cnt  <= 32'(STALL_CYC);
      ph_cnt   <= '0;
      rise_cnt <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (!cs_n) gap_cnt <= '0;
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
      if (sclk != sclk_q) ph_cnt <= 32'd1;
      else if (ph_cnt != '1) ph_cnt <= ph_cnt + 1'b1;
      if (!cs_n && cs_q) rise_cnt <= '0;
      else if (sclk && !sclk_q && !cs_n) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r8_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r8_low_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sclk_q && !cs_n) |-> (ph_cnt == 32'(CLK_DIV)));

  a_r8_rises_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q) |-> (rise_cnt == 8'(FRAME_BITS)));

  a_r7_min_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_q) |-> (gap_cnt >= 32'(STALL_CYC)));

  a_r9_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r9_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !busy);

  a_r4_rvalid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $rose(cs_n));

  a_r4_done_raises_cs: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> cs_n);
endmodule

bind spi_reg_master spi_reg_master_chk #(
  .CLK_DIV(CLK_DIV),
  .STALL_CYC(STALL_CYC),
  .FRAME_BITS(spi_reg_pkg::FRAME_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (spi_cs_n),
  .sclk       (spi_sclk),
  .busy       (busy),
  .rvalid     (rvalid),
  .frame_start(frame_start),
  .frame_done (frame_done)
);

// File: tb/spi_reg_master_test.sv
`timescale 1ns/1ps
module spi_reg_master_test;
  localparam int DIV   = 4;
  localparam int STALL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, rvalid, cs_n, sclk, mosi, miso;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spi_reg_master #(.CLK_DIV(DIV), .STALL_CYC(STALL)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .busy(busy), .rvalid(rvalid), .rdata(rdata),
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    if (i == 'h2B) return 16'h404C;
    return 16'((i * 16'h0111) ^ 16'h3C00);
  endfunction

  // Behavioural sensor: answers each frame with the word chosen by the read before it.
  logic [15:0] sregs [0:63];
  logic [15:0] s_tx = '0, s_rx = '0, s_resp = '0, last_word = '0;
  logic        pcs = 1'bx, psclk = 1'bx, s_init = 1'b0;
  int          s_rises = 0, frames = 0;

  assign miso = s_tx[15];

  always @(cs_n or sclk) begin
    if (!s_init) begin
      for (int i = 0; i < 64; i++) sregs[i] = init_val(i);
      s_init = 1'b1;
    end
    if (pcs === 1'b1 && cs_n === 1'b0) begin
      s_tx = s_resp; s_rx = '0; s_rises = 0;
    end else if (pcs === 1'b0 && cs_n === 1'b1) begin
      if (s_rises == 16) begin
        last_word = s_rx;
        frames++;
        if (s_rx[15]) begin
          if (s_rx[8]) sregs[s_rx[14:9]][15:8] = s_rx[7:0];
          else         sregs[s_rx[14:9]][7:0]  = s_rx[7:0];
          s_resp = '0;
        end else begin
          s_resp = sregs[s_rx[14:9]];
        end
      end
    end else if (cs_n === 1'b0 && psclk === 1'b0 && sclk === 1'b1) begin
      s_rx = {s_rx[14:0], mosi}; s_rises++;
    end else if (cs_n === 1'b0 && psclk === 1'b1 && sclk === 1'b0 && s_rises > 0) begin
      s_tx = {s_tx[14:0], 1'b0};
    end
    pcs = cs_n; psclk = sclk;
  end

  // Scoreboard
  logic [15:0] exp_q [$];
  logic [15:0] shadow [0:63];
  int          rv_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      rv_cnt++;
      check(cs_n == 1'b1, "R4 rvalid outside CS rise", 32'(cs_n), 32'd1);
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected rvalid", 32'(rdata), 32'hFFFFFFFF);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rdata == e, "R4 R5 read data", 32'(rdata), 32'(e));
      end
    end
  end

  // Bus timing monitor
  int   gap = 0, low_len = 0, rises = 0;
  logic m_cs = 1'b1, m_sclk = 1'b1, seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) begin
        gap++;
        if (!m_cs) begin
          check(rises == 16, "R8 rising edges per frame", 32'(rises), 32'd16);
          check(sclk == 1'b1, "R8 SCLK idles high", 32'(sclk), 32'd1);
          rises = 0;
        end
      end else begin
        if (m_cs && seen) check(gap >= STALL, "R7 CS-high gap", 32'(gap), 32'(STALL));
        seen = 1'b1;
        gap = 0;
        if (sclk && !m_sclk) begin
          rises++;
          check(low_len == DIV, "R8 low phase length", 32'(low_len), 32'(DIV));
        end
      end
      if (!sclk) low_len++; else low_len = 0;
      m_cs = cs_n; m_sclk = sclk;
    end
  end

  task automatic host_op(input bit w, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    if (w) begin
      if (a[0]) shadow[a[6:1]][15:8] = d;
      else      shadow[a[6:1]][7:0]  = d;
    end else begin
      exp_q.push_back(shadow[a[6:1]]);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  int f0, rv0;

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = init_val(i);
    repeat (5) @(negedge clk);
    check(cs_n == 1'b1, "R1 CS in reset", 32'(cs_n), 32'd1);
    check(sclk == 1'b1, "R1 SCLK in reset", 32'(sclk), 32'd1);
    check(busy == 1'b0, "R1 busy in reset", 32'(busy), 32'd0);
    check(rvalid == 1'b0, "R1 rvalid in reset", 32'(rvalid), 32'd0);
    rst_n = 1'b1;

    // R5: two reads back to back, R6: dummy frame collects the last one
    host_op(1'b0, 7'h56, 8'h00);
    host_op(1'b0, 7'h56, 8'h00);
    drain();
    check(frames == 3, "R6 frame count after two reads", 32'(frames), 32'd3);
    check(last_word == 16'h0000, "R6 dummy frame word", 32'(last_word), 32'd0);
    check(rv_cnt == 2, "R4 one rvalid per read", 32'(rv_cnt), 32'd2);

    // R2, R3, R10: byte writes
    f0 = frames; rv0 = rv_cnt;
    host_op(1'b1, 7'h3E, 8'hA5);
    drain();
    check(last_word == 16'hBEA5, "R2 write frame word", 32'(last_word), 32'hBEA5);
    check(sregs[31] == {init_val(31)}[15:8] * 256 + 16'hA5 || sregs[31] == {init_val(31)[15:8], 8'hA5},
          "R3 low byte write", 32'(sregs[31]), 32'({init_val(31)[15:8], 8'hA5}));
    host_op(1'b1, 7'h3F, 8'h5A);
    drain();
    check(last_word == 16'hBF5A, "R2 odd-address write word", 32'(last_word), 32'hBF5A);
    check(sregs[31] == 16'h5AA5, "R3 high byte write", 32'(sregs[31]), 32'h5AA5);
    check(rv_cnt == rv0, "R10 no rvalid for writes", 32'(rv_cnt), 32'(rv0));
    check(frames == f0 + 2, "R10 no dummy after writes", 32'(frames), 32'(f0 + 2));

    // R4/R5: mixed chain, write frame collecting a read response
    host_op(1'b0, 7'h3E, 8'h00);
    host_op(1'b0, 7'h10, 8'h00);
    host_op(1'b1, 7'h20, 8'h77);
    host_op(1'b0, 7'h20, 8'h00);
    host_op(1'b0, 7'h21, 8'h00);
    drain();
    check(exp_q.size() == 0, "R4 all reads answered", 32'(exp_q.size()), 32'd0);

    // R9: request raised while a frame is running is ignored
    f0 = frames;
    host_op(1'b1, 7'h22, 8'h99);
    @(negedge clk);
    while (cs_n) @(negedge clk);
    check(busy == 1'b1, "R9 busy during frame", 32'(busy), 32'd1);
    req = 1'b1; we = 1'b1; addr = 7'h10; wdata = 8'hEE;
    @(negedge clk);
    req = 1'b0;
    drain();
    check(frames == f0 + 1, "R9 stray request made no frame", 32'(frames), 32'(f0 + 1));
    host_op(1'b0, 7'h10, 8'h00);
    drain();
    check(exp_q.size() == 0, "R9 readback after stray request", 32'(exp_q.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=busy expected=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule